// File: doc/BRIEF.md
# UART Two-Entry Receive Buffer

This block holds received UART characters between the receive shift register and the CPU read port. Each time a frame completes, the receiver offers the data byte, the received parity bit and its framing check result. The block works out the parity check itself and stores the byte together with a framing tag and a parity tag. Up to two unread bytes are held in first-in first-out order. The oldest one is shown on the read port, and a two-bit fill level says how many are held.

Five single-cycle event pulses go to a separate flag block. Two report loading: one when a byte lands in an empty buffer, and one when a second byte joins a held one. Two report a framing or parity fault, and they fire when the faulty byte becomes the byte shown on the read port, not when it arrives. The fifth reports an overrun: a frame completed while two bytes were held, and that byte was dropped. A synchronous software reset empties the buffer.

Top module: `uart_rx_buf2`

## Requirements
- R1: After reset, fill is 0, the read port shows data 0 with both tags 0, and all five event outputs are 0.
- R2: With parity enabled, a byte's parity tag is 1 when the received parity bit differs from the XOR of the data bits (even mode, par_odd=0) or from its inverse (odd mode, par_odd=1).
- R3: With parity disabled, the parity tag is 0 whatever the parity bit is.
- R4: Bytes with parity or framing faults are stored like any other byte. They are read back in arrival order, each with its own tags, and each pop advances the read port to the next entry.
- R5: The cycle after a byte is stored into a buffer that is empty once any same-cycle pop is applied, ev_one_full pulses for one cycle and fill is 1.
- R6: The cycle after a byte is stored while one entry remains held, ev_two_full pulses for one cycle and fill is 2.
- R7: A frame that completes with two entries held and no pop is dropped. The cycle after, ev_overrun pulses, fill stays 2 and the read port is unchanged.
- R8: ev_frame_err and ev_parity_err pulse in the cycle after a byte carrying that tag becomes the head entry, whether through a store into an empty buffer or a pop that exposes it.
- R9: A pop and a frame arrival in the same cycle with two entries held store the new byte and give no overrun. fill stays 2 and ev_two_full pulses.
- R10: A pop while fill is 0 has no effect: fill stays 0 and no event fires.
- R11: The software reset empties the buffer and clears all tags and events in the next cycle. It takes priority over a frame arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| frame_done | input | 1 | A received frame completes this cycle |
| frame_data | input | DW (8) | Received data byte |
| frame_pbit | input | 1 | Received parity bit |
| frame_ferr | input | 1 | Framing fault of this frame |
| rd_pop | input | 1 | CPU reads and removes the head entry |
| rd_data | output | DW (8) | Head entry data, 0 when empty |
| rd_ferr | output | 1 | Head entry framing tag |
| rd_perr | output | 1 | Head entry parity tag |
| fill | output | 2 | Number of held entries |
| ev_one_full | output | 1 | Byte loaded into empty buffer |
| ev_two_full | output | 1 | Second byte loaded |
| ev_frame_err | output | 1 | Framing-tagged byte became readable |
| ev_parity_err | output | 1 | Parity-tagged byte became readable |
| ev_overrun | output | 1 | Frame dropped, buffer full |

## Verification
A CPU pop and a frame arrival can fall in the same cycle. Their outcome depends on the fill level at that edge. With two bytes held, the pair must count as a store with no overrun. With one byte held, it must count as a store into an emptied buffer and raise the one-full event. The vector table drives both pairings, and also a pop that exposes a doubly tagged byte while a new byte arrives. Each case is judged by the next-cycle fill, head data, tags and the exact set of event pulses.

// File: rtl/uart_rx_buf2.sv
module uart_rx_buf2 #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_data,
  input  logic          frame_pbit,
  input  logic          frame_ferr,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_ferr,
  output logic          rd_perr,
  output logic [1:0]    fill,
  output logic          ev_one_full,
  output logic          ev_two_full,
  output logic          ev_frame_err,
  output logic          ev_parity_err,
  output logic          ev_overrun
);
  localparam int EW = DW + 2;

  logic [EW-1:0] ent0, ent1, inc, head_nxt;
  logic [1:0]    cnt, base;
  logic          pe_in, pop_ok, store, drop, new_head;

  assign pe_in    = par_en & (frame_pbit != ((^frame_data) ^ par_odd));
  assign inc      = {frame_ferr, pe_in, frame_data};
  assign pop_ok   = rd_pop & (cnt != 2'd0);
  assign base     = cnt - {1'b0, pop_ok};
  assign store    = frame_done & (base != 2'd2);
  assign drop     = frame_done & (base == 2'd2);
  assign new_head = (store & (base == 2'd0)) | (pop_ok & (cnt == 2'd2));
  assign head_nxt = (pop_ok & (cnt == 2'd2)) ? ent1 : inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent0 <= '0; ent1 <= '0; cnt <= '0;
      ev_one_full <= 1'b0; ev_two_full <= 1'b0; ev_overrun <= 1'b0;
      ev_frame_err <= 1'b0; ev_parity_err <= 1'b0;
    end else if (sw_rst) begin
      ent0 <= '0; ent1 <= '0; cnt <= '0;
      ev_one_full <= 1'b0; ev_two_full <= 1'b0; ev_overrun <= 1'b0;
      ev_frame_err <= 1'b0; ev_parity_err <= 1'b0;
    end else begin
      if (pop_ok) begin
        ent0 <= ent1;
        ent1 <= '0;
      end
      if (store) begin
        if (base == 2'd0) ent0 <= inc;
        else              ent1 <= inc;
      end
      cnt           <= base + {1'b0, store};
      ev_one_full   <= store & (base == 2'd0);
      ev_two_full   <= store & (base == 2'd1);
      ev_overrun    <= drop;
      ev_frame_err  <= new_head & head_nxt[DW+1];
      ev_parity_err <= new_head & head_nxt[DW];
    end
  end

  assign rd_data = ent0[DW-1:0];
  assign rd_perr = ent0[DW];
  assign rd_ferr = ent0[DW+1];
  assign fill    = cnt;
endmodule

// File: rtl/uart_rx_buf2_chk.sv
module uart_rx_buf2_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_rst,
  input logic       frame_done,
  input logic       rd_pop,
  input logic [1:0] fill,
  input logic       rd_ferr,
  input logic       rd_perr,
  input logic       ev_one_full,
  input logic       ev_two_full,
  input logic       ev_frame_err,
  input logic       ev_parity_err,
  input logic       ev_overrun
);
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill != 2'd3);

  assert_load_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && fill == 2'd0 && !sw_rst) |=> (ev_one_full && fill == 2'd1));

  assert_load_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && fill == 2'd1 && !rd_pop && !sw_rst) |=> (ev_two_full && fill == 2'd2));

  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && fill == 2'd2 && !rd_pop && !sw_rst) |=> (ev_overrun && fill == 2'd2 && $stable({rd_ferr, rd_perr})));

  assert_err_at_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_frame_err -> rd_ferr) && (ev_parity_err -> rd_perr) && ((ev_frame_err || ev_parity_err) -> fill != 2'd0)));

  assert_pop_and_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rd_pop && fill == 2'd2 && !sw_rst) |=> (!ev_overrun && ev_two_full && fill == 2'd2));

  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !frame_done && fill == 2'd0 && !sw_rst) |=> (fill == 2'd0 && !ev_one_full && !ev_overrun));

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (fill == 2'd0 && !ev_one_full && !ev_two_full && !ev_overrun && !ev_frame_err && !ev_parity_err));
endmodule

bind uart_rx_buf2 uart_rx_buf2_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .frame_done(frame_done), .rd_pop(rd_pop),
  .fill(fill), .rd_ferr(rd_ferr), .rd_perr(rd_perr), .ev_one_full(ev_one_full),
  .ev_two_full(ev_two_full), .ev_frame_err(ev_frame_err), .ev_parity_err(ev_parity_err),
  .ev_overrun(ev_overrun)
);

// File: tb/tb_uart_rx_buf2.sv
module tb_uart_rx_buf2;
  logic clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0, par_en = 1'b1, par_odd = 1'b0;
  logic frame_done = 1'b0, frame_pbit = 1'b0, frame_ferr = 1'b0, rd_pop = 1'b0;
  logic [7:0] frame_data = '0, rd_data;
  logic rd_ferr, rd_perr, ev_one_full, ev_two_full, ev_frame_err, ev_parity_err, ev_overrun;
  logic [1:0] fill;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_buf2 #(.DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .par_en(par_en), .par_odd(par_odd),
    .frame_done(frame_done), .frame_data(frame_data), .frame_pbit(frame_pbit),
    .frame_ferr(frame_ferr), .rd_pop(rd_pop), .rd_data(rd_data), .rd_ferr(rd_ferr),
    .rd_perr(rd_perr), .fill(fill), .ev_one_full(ev_one_full), .ev_two_full(ev_two_full),
    .ev_frame_err(ev_frame_err), .ev_parity_err(ev_parity_err), .ev_overrun(ev_overrun));

  // {push, pop, data, pbit, ferr, exp_fill, exp_data, exp_pe, exp_fe, exp_ev{one,two,fe,pe,ovr}}
  localparam logic [28:0] VEC [13] = '{
    {1'b1,1'b0,8'hA5,1'b0,1'b0,2'd1,8'hA5,1'b0,1'b0,5'b10000},
    {1'b1,1'b0,8'h3C,1'b1,1'b0,2'd2,8'hA5,1'b0,1'b0,5'b01000},
    {1'b1,1'b0,8'h7E,1'b0,1'b1,2'd2,8'hA5,1'b0,1'b0,5'b00001},
    {1'b0,1'b1,8'h00,1'b0,1'b0,2'd1,8'h3C,1'b1,1'b0,5'b00010},
    {1'b0,1'b1,8'h00,1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,5'b00000},
    {1'b0,1'b1,8'h00,1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,5'b00000},
    {1'b1,1'b0,8'h81,1'b0,1'b1,2'd1,8'h81,1'b0,1'b1,5'b10100},
    {1'b1,1'b0,8'h01,1'b1,1'b0,2'd2,8'h81,1'b0,1'b1,5'b01000},
    {1'b1,1'b1,8'hFF,1'b1,1'b1,2'd2,8'h01,1'b0,1'b0,5'b01000},
    {1'b1,1'b1,8'h00,1'b0,1'b0,2'd2,8'hFF,1'b1,1'b1,5'b01110},
    {1'b0,1'b1,8'h00,1'b0,1'b0,2'd1,8'h00,1'b0,1'b0,5'b00000},
    {1'b1,1'b1,8'h55,1'b0,1'b0,2'd1,8'h55,1'b0,1'b0,5'b10000},
    {1'b0,1'b1,8'h00,1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,5'b00000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] evs();
    return {ev_one_full, ev_two_full, ev_frame_err, ev_parity_err, ev_overrun};
  endfunction

  task automatic step(input logic push, input logic pop, input logic [7:0] d,
                      input logic pb, input logic fe, input logic sr);
    @(negedge clk);
    frame_done = push; rd_pop = pop; frame_data = d; frame_pbit = pb; frame_ferr = fe; sw_rst = sr;
    @(posedge clk);
    #1;
    frame_done = 0; rd_pop = 0; sw_rst = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #9;
    check("R1 reset fill/data/tags", {6'd0, fill, rd_data}, 16'd0);
    check("R1 reset events", {11'd0, evs()}, {11'd0, rd_perr|rd_ferr, 4'd0});
    @(negedge clk); rst_n = 1;

    // Vector table: R4 R5 R6 R7 R8 R9 R10 and parity R2 (even)
    for (int i = 0; i < 13; i++) begin
      logic [28:0] v;
      v = VEC[i];
      step(v[28], v[27], v[26:19], v[18], v[17], 1'b0);
      check($sformatf("R4 vec%0d fill/data", i), {6'd0, fill, rd_data}, {6'd0, v[16:15], v[14:7]});
      check($sformatf("R2 vec%0d tags pe/fe", i), {14'd0, rd_perr, rd_ferr}, {14'd0, v[6], v[5]});
      check($sformatf("R8 vec%0d events", i), {11'd0, evs()}, {11'd0, v[4:0]});
    end

    // R11: software reset with simultaneous arrival
    step(1, 0, 8'h12, 0, 1, 0);
    step(1, 0, 8'h34, 1, 0, 0);
    step(1, 0, 8'h56, 0, 0, 1);
    check("R11 sw reset empties", {6'd0, fill, rd_data}, 16'd0);
    check("R11 sw reset events/tags", {9'd0, evs(), rd_perr, rd_ferr}, 16'd0);
    step(0, 1, 8'h00, 0, 0, 0);
    check("R11 stays empty after pop", {14'd0, fill}, 16'd0);

    // R3: parity disabled, wrong parity bit ignored
    par_en = 0;
    step(1, 0, 8'h01, 0, 0, 0);
    check("R3 parity off no tag", {7'd0, rd_perr, rd_data}, {7'd0, 1'b0, 8'h01});
    check("R3 parity off no event", {11'd0, evs()}, {11'd0, 5'b10000});
    step(0, 1, 8'h00, 0, 0, 0);

    // R2: odd parity
    par_en = 1; par_odd = 1;
    step(1, 0, 8'h00, 1, 0, 0);
    check("R2 odd good parity", {15'd0, rd_perr}, 16'd0);
    step(1, 0, 8'h00, 0, 0, 0);
    check("R2 odd second no event yet", {11'd0, evs()}, {11'd0, 5'b01000});
    step(0, 1, 8'h00, 0, 0, 0);
    check("R2 odd bad parity tagged", {15'd0, rd_perr}, 16'd1);
    check("R8 parity event on expose", {11'd0, evs()}, {11'd0, 5'b00010});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule